// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block guards a small configuration space behind two adjacent byte ports. The lower port, the index port, takes a register number and the upper port, the data port, reads or writes the register that number selects. After reset the space is sealed. Index-port writes go to a key checker, data-port reads return 0xFF and data-port writes are dropped. The space opens only after the four-byte key 0x87, 0x01, 0x55, 0x55 has been written to the index port in that order.

Once open, index 0x07 holds the logical device number. Indices 0x30 and above are passed through a simple register-file interface to the bank of that device. Indices below 0x30 are global, and among them sit a read-only 16-bit chip identifier and a revision nibble. Writing 0x02 to index 0x02 seals the space again.

The key checker is a five-state machine. Its states are KEY0, KEY1, KEY2, KEY3 and OPEN. In KEY0 to KEY3 the machine waits for key byte 0 to key byte 3. The transitions are:
- advance: an index write that carries the expected byte moves to the next state.
- restart: an index write of 0x87 that is not the expected byte moves to KEY1.
- fallback: any other byte moves to KEY0.
- exit: in OPEN, the exit write returns to KEY0.

Top module: `cfgp_top`

## Requirements
- R1: After reset the port is sealed: both ports read 0xFF. Once unlocked, the index register and the logical device number both read 0x00.
- R2: Writing 0x87, 0x01, 0x55, 0x55 to the index port (bus_addr=0) in consecutive index writes opens the port. The next index-port read returns the latched index, which is 0x00.
- R3: A byte that does not match the expected key byte sends the checker back to KEY0. If that byte is 0x87, the checker goes to KEY1 instead, so 0x87,0x87,0x01,0x55,0x55 opens the port.
- R4: While sealed, data-port (bus_addr=1) reads return 0xFF and data-port writes change no register and raise no device strobe.
- R5: While open, an index-port write latches the byte as the current index, and an index-port read returns it.
- R6: Index 0x07 is a read/write logical device number, and it changes only on a data write at that index while open.
- R7: Indices 0x20 and 0x21 return the high and low byte of the CHIP_ID parameter (default 0x5A31), and writes to them are ignored.
- R8: Index 0x22 returns the CHIP_REV parameter (default 0x6) in bits 3:0, with bits 7:4 zero.
- R9: While open, a data access at an index of 0x30 or above raises dev_wr or dev_rd with dev_sel equal to the logical device number, dev_addr equal to the index and dev_wdata equal to the written byte. A read returns dev_rdata. Indices below 0x30 raise no strobe.
- R10: Writing 0x02 to the data port at index 0x02 seals the port from the next cycle and clears the index. Any other value written there does not seal it.
- R11: After sealing, index-port writes feed the key checker again and do not select registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 selects the index port, 1 the data port |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe; bus_rdata is valid while it is high |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| dev_sel | output | 8 | Selected logical device number |
| dev_addr | output | 8 | Device register index |
| dev_wr | output | 1 | Device register write strobe |
| dev_rd | output | 1 | Device register read strobe |
| dev_wdata | output | 8 | Device register write byte |
| dev_rdata | input | 8 | Device register read byte |

## Verification
A key checker left in the wrong step shows up on the first index-port read after the fourth key byte: the read gives 0xFF instead of the index, or gives the index after a broken sequence. A stale index or device number shows on the next data-port read. It shows at once on dev_sel and dev_addr during a banked access. A missed exit leaves the index port readable in the cycle after the exit write, where a sealed port must return 0xFF.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_KEY0,
        ST_KEY1,
        ST_KEY2,
        ST_KEY3,
        ST_OPEN
    } key_state_t;

    localparam logic [BYTE_W-1:0] IDX_EXIT = 8'h02;
    localparam logic [BYTE_W-1:0] VAL_EXIT = 8'h02;
    localparam logic [BYTE_W-1:0] IDX_LDN  = 8'h07;
    localparam logic [BYTE_W-1:0] IDX_IDHI = 8'h20;
    localparam logic [BYTE_W-1:0] IDX_IDLO = 8'h21;
    localparam logic [BYTE_W-1:0] IDX_REV  = 8'h22;
    localparam logic [BYTE_W-1:0] IDX_BANK = 8'h30;
endpackage

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
    import cfgp_pkg::*;
#(
    parameter logic [4*BYTE_W-1:0] KEY_SEQ = 32'h87_01_55_55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic [BYTE_W-1:0] key_byte,
    input  logic              exit_req,
    output logic              open
);
    localparam logic [BYTE_W-1:0] K0 = KEY_SEQ[4*BYTE_W-1 -: BYTE_W];
    localparam logic [BYTE_W-1:0] K1 = KEY_SEQ[3*BYTE_W-1 -: BYTE_W];
    localparam logic [BYTE_W-1:0] K2 = KEY_SEQ[2*BYTE_W-1 -: BYTE_W];
    localparam logic [BYTE_W-1:0] K3 = KEY_SEQ[BYTE_W-1   -: BYTE_W];

    key_state_t state, nxt;

    // on a mismatch, a first key byte restarts at step two
    function automatic key_state_t miss(input logic [BYTE_W-1:0] b);
        return (b == K0) ? ST_KEY1 : ST_KEY0;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_KEY0;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_KEY0: if (key_wr) nxt = (key_byte == K0) ? ST_KEY1 : ST_KEY0;
            ST_KEY1: if (key_wr) nxt = (key_byte == K1) ? ST_KEY2 : miss(key_byte);
            ST_KEY2: if (key_wr) nxt = (key_byte == K2) ? ST_KEY3 : miss(key_byte);
            ST_KEY3: if (key_wr) nxt = (key_byte == K3) ? ST_OPEN : miss(key_byte);
            ST_OPEN: if (exit_req) nxt = ST_KEY0;
            default: nxt = ST_KEY0;
        endcase
    end

    always_comb open = (state == ST_OPEN);

    assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_KEY3 && key_wr && key_byte == K3) |=> open);

    assert_restart_step_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && key_wr && key_byte == K0) |=> (state == ST_KEY1));

    assert_exit_seals_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (open && exit_req) |=> (state == ST_KEY0));
endmodule

// File: rtl/cfgp_index_bank.sv
module cfgp_index_bank
    import cfgp_pkg::*;
#(
    parameter logic [15:0] CHIP_ID  = 16'h5A31,
    parameter logic [3:0]  CHIP_REV = 4'h6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              exit_req,
    output logic [BYTE_W-1:0] dev_sel,
    output logic [BYTE_W-1:0] dev_addr,
    output logic              dev_wr,
    output logic              dev_rd,
    output logic [BYTE_W-1:0] dev_wdata,
    input  logic [BYTE_W-1:0] dev_rdata
);
    logic [BYTE_W-1:0] idx_q, ldn_q;
    logic idx_wr, dat_wr, dat_rd, banked;

    always_comb begin
        idx_wr   = open && bus_wr && !bus_addr;
        dat_wr   = open && bus_wr &&  bus_addr;
        dat_rd   = open && bus_rd &&  bus_addr;
        banked   = (idx_q >= IDX_BANK);
        exit_req = dat_wr && idx_q == IDX_EXIT && bus_wdata == VAL_EXIT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        idx_q <= '0;
        else if (exit_req) idx_q <= '0;
        else if (idx_wr)   idx_q <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ldn_q <= '0;
        else if (dat_wr && idx_q == IDX_LDN) ldn_q <= bus_wdata;
    end

    always_comb begin
        dev_sel   = ldn_q;
        dev_addr  = idx_q;
        dev_wdata = bus_wdata;
        dev_wr    = dat_wr && banked;
        dev_rd    = dat_rd && banked;
    end

    always_comb begin
        if (!open)         bus_rdata = 8'hFF;
        else if (!bus_addr) bus_rdata = idx_q;
        else if (banked)   bus_rdata = dev_rdata;
        else begin
            unique case (idx_q)
                IDX_LDN:  bus_rdata = ldn_q;
                IDX_IDHI: bus_rdata = CHIP_ID[15:8];
                IDX_IDLO: bus_rdata = CHIP_ID[7:0];
                IDX_REV:  bus_rdata = {4'h0, CHIP_REV};
                default:  bus_rdata = 8'h00;
            endcase
        end
    end

    assert_no_dev_when_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !open |-> (!dev_wr && !dev_rd));

    assert_ldn_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(open && bus_wr && bus_addr && idx_q == IDX_LDN) |=> $stable(ldn_q));

    assert_dev_only_banked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr || dev_rd) |-> (dev_addr >= IDX_BANK));

    assert_exit_clears_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exit_req |=> (idx_q == '0));
endmodule

// File: rtl/cfgp_top.sv
module cfgp_top
    import cfgp_pkg::*;
#(
    parameter logic [4*BYTE_W-1:0] KEY_SEQ  = 32'h87_01_55_55,
    parameter logic [15:0]         CHIP_ID  = 16'h5A31,
    parameter logic [3:0]          CHIP_REV = 4'h6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic [7:0] dev_sel,
    output logic [7:0] dev_addr,
    output logic       dev_wr,
    output logic       dev_rd,
    output logic [7:0] dev_wdata,
    input  logic [7:0] dev_rdata
);
    logic open, exit_req, key_wr;

    always_comb key_wr = bus_wr && !bus_addr;

    cfgp_key_fsm #(.KEY_SEQ(KEY_SEQ)) u_key (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_byte(bus_wdata),
        .exit_req(exit_req), .open(open)
    );

    cfgp_index_bank #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_bank (
        .clk(clk), .rst_n(rst_n), .open(open), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .exit_req(exit_req), .dev_sel(dev_sel),
        .dev_addr(dev_addr), .dev_wr(dev_wr), .dev_rd(dev_rd),
        .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    assert_sealed_reads_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && bus_rd) |-> (bus_rdata == 8'hFF));
endmodule

// File: tb/sim_cfgp_top.sv
module sim_cfgp_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic [7:0] dev_sel, dev_addr, dev_wdata, dev_rdata;
    logic dev_wr, dev_rd;
    int n_cmp = 0, n_bad = 0, n_devwr = 0, base;
    logic [7:0] last_sel, last_addr, last_data, got;

    always #2 clk = ~clk;

    cfgp_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_sel(dev_sel), .dev_addr(dev_addr), .dev_wr(dev_wr),
        .dev_rd(dev_rd), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
    );

    // device bank model: returns {device[3:0], index[3:0]}
    assign dev_rdata = {dev_sel[3:0], dev_addr[3:0]};

    always @(posedge clk) if (dev_wr) begin
        n_devwr   <= n_devwr + 1;
        last_sel  <= dev_sel;
        last_addr <= dev_addr;
        last_data <= dev_wdata;
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic unlock();
        wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h55);
    endtask

    // {is_read, port, write byte, expected byte, requirement}
    localparam int NV = 24;
    localparam logic [21:0] VEC [0:NV-1] = '{
        {1'b1, 1'b1, 8'h00, 8'hFF, 4'd1},   // R1 sealed data read
        {1'b0, 1'b0, 8'h87, 8'h00, 4'd2},   // R2 key
        {1'b0, 1'b0, 8'h01, 8'h00, 4'd2},
        {1'b0, 1'b0, 8'h55, 8'h00, 4'd2},
        {1'b0, 1'b0, 8'h55, 8'h00, 4'd2},
        {1'b1, 1'b0, 8'h00, 8'h00, 4'd2},   // R2 index readable
        {1'b0, 1'b0, 8'h20, 8'h00, 4'd7},
        {1'b1, 1'b1, 8'h00, 8'h5A, 4'd7},   // R7 id high
        {1'b0, 1'b0, 8'h21, 8'h00, 4'd7},
        {1'b1, 1'b1, 8'h00, 8'h31, 4'd7},   // R7 id low
        {1'b0, 1'b0, 8'h22, 8'h00, 4'd8},
        {1'b1, 1'b1, 8'h00, 8'h06, 4'd8},   // R8 revision
        {1'b0, 1'b0, 8'h07, 8'h00, 4'd6},
        {1'b0, 1'b1, 8'h03, 8'h00, 4'd6},
        {1'b1, 1'b1, 8'h00, 8'h03, 4'd6},   // R6 device number
        {1'b1, 1'b0, 8'h00, 8'h07, 4'd5},   // R5 index latch
        {1'b0, 1'b0, 8'h35, 8'h00, 4'd9},
        {1'b1, 1'b1, 8'h00, 8'h35, 4'd9},   // R9 banked read
        {1'b0, 1'b0, 8'h02, 8'h00, 4'd10},
        {1'b0, 1'b1, 8'h05, 8'h00, 4'd10},  // R10 wrong exit value
        {1'b1, 1'b0, 8'h00, 8'h02, 4'd10},
        {1'b0, 1'b1, 8'h02, 8'h00, 4'd10},  // R10 exit
        {1'b1, 1'b0, 8'h00, 8'hFF, 4'd10},
        {1'b1, 1'b1, 8'h00, 8'hFF, 4'd4}    // R4 sealed read
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(0, got); check("R1 sealed index read", got, 8'hFF);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][21]) begin
                rd(VEC[i][20], got);
                check($sformatf("R%0d vector %0d", VEC[i][3:0], i), got, VEC[i][11:4]);
            end else begin
                wr(VEC[i][20], VEC[i][19:12]);
            end
        end

        // R4: sealed data write has no effect
        base = n_devwr;
        wr(1, 8'h44);
        check("R4 no strobe when sealed", 8'(n_devwr - base), 8'h00);
        unlock(); wr(0, 8'h07); rd(1, got); check("R4 ldn kept", got, 8'h03);

        // R9: banked write and unbanked write
        base = n_devwr;
        wr(0, 8'h40); wr(1, 8'hA5);
        check("R9 strobe count", 8'(n_devwr - base), 8'h01);
        check("R9 dev_sel", last_sel, 8'h03);
        check("R9 dev_addr", last_addr, 8'h40);
        check("R9 dev_wdata", last_data, 8'hA5);
        wr(0, 8'h10); wr(1, 8'h77);
        check("R9 no strobe below bank", 8'(n_devwr - base), 8'h01);

        // R7: id is read-only
        wr(0, 8'h20); wr(1, 8'h00); rd(1, got); check("R7 id write ignored", got, 8'h5A);

        // R11: after exit, index writes go to the key checker
        wr(0, 8'h02); wr(1, 8'h02);
        wr(0, 8'h20); rd(1, got); check("R11 data sealed", got, 8'hFF);
        rd(0, got); check("R11 index sealed", got, 8'hFF);

        // R3: wrong byte falls back; 0x87 restarts at step two
        wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h13); wr(0, 8'h55); wr(0, 8'h55);
        rd(0, got); check("R3 broken key stays sealed", got, 8'hFF);
        wr(0, 8'h87); wr(0, 8'h87); wr(0, 8'h01); wr(0, 8'h55); wr(0, 8'h55);
        rd(0, got); check("R3 repeated first byte opens", got, 8'h00);

        // R1: reset while open
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        rd(0, got); check("R1 sealed after reset", got, 8'hFF);
        unlock(); wr(0, 8'h07); rd(1, got); check("R1 ldn reset", got, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule